// File: doc/BRIEF.md
# Four-CPU Device Interrupt Router

This block steers a shared vector of raw device interrupt requests to up to four processors. Each CPU owns a 64-bit mask register. The pending view for that CPU is the AND of its mask with the raw vector, and each CPU receives one level interrupt line. That line is high whenever any bit of its pending view is set. The block also holds a 24-bit interval-ignore count for each CPU.

Every register is 64 bits wide, but the block is reached over a 32-bit bus. Software moves a 64-bit value in two halves through one 32-bit holding latch:

- **Reads.** Reading the low half returns bits 31:0 and parks bits 63:32 in the latch. Reading the high half returns the latch.
- **Writes.** Writing the low half only loads the latch. Writing the high half joins the new word with the latch and commits the full 64-bit value.

Some offsets are reserved for configuration that lives elsewhere; they read as zero and ignore writes. Any other offset is an error.

The bus is single-cycle: read data and the error flag are valid in the same cycle as the enable, and state changes at the next rising clock edge.

Top module: `irq_router`

## Requirements
- R1: After reset all masks, all interval-ignore counts and the holding latch are zero. Every `cpuIrq` line is low, and `busRdData` is zero while no read is enabled.
- R2: A write with `busAddr[2]`=0 loads only the holding latch; no register changes.
- R3: A write with `busAddr[2]`=1 commits {`busWrData`, latch} to the register at the address with bit 2 cleared. The mask offsets are 0x200, 0x240, 0x600 and 0x640 for CPU0 to CPU3.
- R4: A read with `busAddr[2]`=0 returns bits 31:0 of the register in the same cycle and captures bits 63:32 into the latch. A read with `busAddr[2]`=1 returns the latch.
- R5: Offsets 0x280, 0x2C0, 0x680 and 0x6C0 (CPU0 to CPU3) read as that CPU's mask AND the raw vector. Writes to them change nothing.
- R6: Offset 0x300 reads the raw request vector. Writes to it change nothing.
- R7: Interval-ignore counts sit at 0x380, 0x3C0, 0x700 and 0x740 (CPU0 to CPU3). Each keeps only bits 23:0 of a committed value, and bits 63:24 read as zero.
- R8: `cpuIrq[i]` equals the OR of (mask i AND `rawReq`) at all times. It follows `rawReq` within the same cycle and reflects a new mask from the clock edge that commits it.
- R9: The reserved offsets read zero without an error and ignore writes. They are 0x000, 0x040, 0x080, 0x0C0, 0x100, 0x140, 0x180, 0x1C0, 0x340, 0x400, 0x440, 0x480, 0x4C0, 0x580, 0x5C0, 0x780, 0xC00, 0xC40, 0xC80 and 0xCC0.
- R10: `accessErr` is high in the cycle of any of these accesses, which change no state (including the latch), and a read of this kind returns 0xFFFFFFFF:
  - a low-half read of an unmapped offset;
  - a high-half write to an unmapped offset;
  - any access with `busAddr[1:0]`≠0.
- R11: When `busWrEn` and `busRdEn` are both high, only the write is performed: `busRdData` is zero and the read does not load the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the cycle of the read |
| accessErr | output | 1 | Unmapped or misaligned access in this cycle |
| rawReq | input | RAW_W | Raw device interrupt requests |
| cpuIrq | output | 4 | Level interrupt, one per CPU |

## Verification
Two functions can act in the same cycle: a mask commit and a change of the raw request inputs. Both feed the same interrupt line. The bench commits a zero mask for CPU0 in the very cycle that `rawReq` switches to a value this mask still catches.

Before the edge, the line must show the old mask against the new raw vector. After the edge, it must show the new mask. A one-cycle slip in either direction is reported.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int NUM_CPU = 4;
  localparam int CPU_W   = $clog2(NUM_CPU);
  localparam int ADDR_W  = 12;

  typedef enum logic [2:0] {
    RD_ZERO, RD_MASK, RD_PEND, RD_RAW, RD_IIC, RD_ONES
  } rdSel_e;

  typedef enum logic [2:0] {
    KIND_NONE, KIND_MASK, KIND_PEND, KIND_RAW, KIND_IIC, KIND_RSVD
  } regKind_e;

  typedef struct packed {
    logic               holdFromBus;
    logic               holdFromRead;
    logic               readHigh;
    logic [NUM_CPU-1:0] maskWe;
    logic [NUM_CPU-1:0] iicWe;
    rdSel_e             rdSel;
    logic [CPU_W-1:0]   cpuSel;
    logic               accessErr;
  } strobe_t;
endpackage

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           stb
);
  logic [ADDR_W-1:0] offset;
  logic              aligned;
  logic              highHalf;
  regKind_e          kind;
  logic [CPU_W-1:0]  cpuIdx;

  assign offset   = {busAddr[ADDR_W-1:3], 3'b000};
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign highHalf = busAddr[2];

  // Offset decode: register kind and the CPU it belongs to
  always_comb begin
    kind   = KIND_NONE;
    cpuIdx = '0;
    case (offset)
      12'h200: begin kind = KIND_MASK; cpuIdx = 2'd0; end
      12'h240: begin kind = KIND_MASK; cpuIdx = 2'd1; end
      12'h600: begin kind = KIND_MASK; cpuIdx = 2'd2; end
      12'h640: begin kind = KIND_MASK; cpuIdx = 2'd3; end
      12'h280: begin kind = KIND_PEND; cpuIdx = 2'd0; end
      12'h2C0: begin kind = KIND_PEND; cpuIdx = 2'd1; end
      12'h680: begin kind = KIND_PEND; cpuIdx = 2'd2; end
      12'h6C0: begin kind = KIND_PEND; cpuIdx = 2'd3; end
      12'h380: begin kind = KIND_IIC;  cpuIdx = 2'd0; end
      12'h3C0: begin kind = KIND_IIC;  cpuIdx = 2'd1; end
      12'h700: begin kind = KIND_IIC;  cpuIdx = 2'd2; end
      12'h740: begin kind = KIND_IIC;  cpuIdx = 2'd3; end
      12'h300: kind = KIND_RAW;
      12'h000, 12'h040, 12'h080, 12'h0C0,
      12'h100, 12'h140, 12'h180, 12'h1C0,
      12'h340, 12'h400, 12'h440, 12'h480, 12'h4C0,
      12'h580, 12'h5C0, 12'h780,
      12'hC00, 12'hC40, 12'hC80, 12'hCC0: kind = KIND_RSVD;
      default: kind = KIND_NONE;
    endcase
  end

  // Strobe generation; a write wins over a simultaneous read
  always_comb begin
    stb        = '0;
    stb.rdSel  = RD_ZERO;
    stb.cpuSel = cpuIdx;
    if (busWrEn) begin
      if (!aligned)                stb.accessErr   = 1'b1;
      else if (!highHalf)          stb.holdFromBus = 1'b1;
      else if (kind == KIND_NONE)  stb.accessErr   = 1'b1;
      else if (kind == KIND_MASK)  stb.maskWe[cpuIdx] = 1'b1;
      else if (kind == KIND_IIC)   stb.iicWe[cpuIdx]  = 1'b1;
    end else if (busRdEn) begin
      if (!aligned) begin
        stb.accessErr = 1'b1;
        stb.rdSel     = RD_ONES;
      end else if (highHalf) begin
        stb.readHigh = 1'b1;
      end else if (kind == KIND_NONE) begin
        stb.accessErr = 1'b1;
        stb.rdSel     = RD_ONES;
      end else begin
        stb.holdFromRead = 1'b1;
        case (kind)
          KIND_MASK: stb.rdSel = RD_MASK;
          KIND_PEND: stb.rdSel = RD_PEND;
          KIND_RAW:  stb.rdSel = RD_RAW;
          KIND_IIC:  stb.rdSel = RD_IIC;
          default:   stb.rdSel = RD_ZERO;
        endcase
      end
    end
  end

  // R10: an erroneous access neither commits nor touches the latch
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.accessErr |-> (stb.maskWe == '0 && stb.iicWe == '0 &&
                       !stb.holdFromBus && !stb.holdFromRead));

  // R11: a write cycle never captures read data into the latch
  p_write_no_capture_r11: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> !stb.holdFromRead && !stb.readHigh);

  // R2: a low-half write never commits a register
  p_low_write_no_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busAddr[2]) |-> (stb.maskWe == '0 && stb.iicWe == '0));
endmodule

// File: rtl/irq_route_dp.sv
`timescale 1ns/1ps
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int RAW_W = 64,
  parameter int IIC_W = 24
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [31:0]        busWrData,
  input  logic [RAW_W-1:0]   rawReq,
  output logic [31:0]        busRdData,
  output logic [NUM_CPU-1:0] cpuIrq
);
  logic [31:0]                    holdLatch;
  logic [NUM_CPU-1:0][RAW_W-1:0]  maskReg;
  logic [NUM_CPU-1:0][IIC_W-1:0]  iicReg;
  logic [63:0]                    commitVal;
  logic [63:0]                    readVal;

  assign commitVal = {busWrData, holdLatch};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLatch <= '0;
      maskReg   <= '0;
      iicReg    <= '0;
    end else begin
      if (stb.holdFromBus)       holdLatch <= busWrData;
      else if (stb.holdFromRead) holdLatch <= readVal[63:32];
      for (int c = 0; c < NUM_CPU; c++) begin
        if (stb.maskWe[c]) maskReg[c] <= commitVal[RAW_W-1:0];
        if (stb.iicWe[c])  iicReg[c]  <= commitVal[IIC_W-1:0];
      end
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_MASK: readVal = 64'(maskReg[stb.cpuSel]);
      RD_PEND: readVal = 64'(maskReg[stb.cpuSel] & rawReq);
      RD_RAW:  readVal = 64'(rawReq);
      RD_IIC:  readVal = 64'(iicReg[stb.cpuSel]);
      default: readVal = '0;
    endcase
  end

  assign busRdData = stb.readHigh ? holdLatch :
                     (stb.rdSel == RD_ONES) ? 32'hFFFF_FFFF : readVal[31:0];

  for (genvar g = 0; g < NUM_CPU; g++) begin : gen_cpu
    assign cpuIrq[g] = |(maskReg[g] & rawReq);

    // R8: committing an all-zero mask silences the line from the next cycle
    p_zero_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stb.maskWe[g] && commitVal == '0) |=> !cpuIrq[g]);
  end

  // R2: the latch only moves on a latch strobe
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.holdFromBus && !stb.holdFromRead) |=> $stable(holdLatch));

  // R3: a commit leaves the latch as it was
  p_commit_keeps_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskWe != '0 || stb.iicWe != '0) |=> $stable(holdLatch));
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_route_pkg::*;
#(
  parameter int RAW_W = 64,
  parameter int IIC_W = 24
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               accessErr,
  input  logic [RAW_W-1:0]   rawReq,
  output logic [3:0]         cpuIrq
);
  strobe_t stb;

  irq_route_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .stb     (stb)
  );

  irq_route_dp #(.RAW_W(RAW_W), .IIC_W(IIC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWrData (busWrData),
    .rawReq    (rawReq),
    .busRdData (busRdData),
    .cpuIrq    (cpuIrq)
  );

  assign accessErr = stb.accessErr;

  // R10: a failing read returns all ones
  p_ones_on_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && accessErr) |-> busRdData == 32'hFFFF_FFFF);

  // R11: no read data during a write cycle
  p_no_data_on_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> busRdData == 32'h0);
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        accessErr;
  logic [63:0] rawReq = '0;
  logic [3:0]  cpuIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] rdS;
  logic        errS;
  logic [3:0]  irqS;

  always #10 clk = ~clk;  // 50 MHz

  irq_router u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .accessErr(accessErr), .rawReq(rawReq), .cpuIrq(cpuIrq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic        chkRd;
    logic [31:0] expRd;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 44;
  // rawReq is 64'h8000_0001_0000_00F0 while the table runs
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h200, 32'h0,        1'b1, 32'h0,        1'b0, 4'd1},  // R1
    '{1'b0, 12'h604, 32'h0,        1'b1, 32'h0,        1'b0, 4'd1},  // R1 latch
    '{1'b0, 12'h380, 32'h0,        1'b1, 32'h0,        1'b0, 4'd1},  // R1
    '{1'b1, 12'h200, 32'hF0,       1'b0, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b0, 12'h200, 32'h0,        1'b1, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b1, 12'h200, 32'hF0,       1'b0, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b1, 12'h204, 32'h8000_0000,1'b0, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b0, 12'h200, 32'h0,        1'b1, 32'hF0,       1'b0, 4'd4},  // R4
    '{1'b0, 12'h204, 32'h0,        1'b1, 32'h8000_0000,1'b0, 4'd4},  // R4
    '{1'b0, 12'h280, 32'h0,        1'b1, 32'hF0,       1'b0, 4'd5},  // R5
    '{1'b0, 12'h284, 32'h0,        1'b1, 32'h8000_0000,1'b0, 4'd5},  // R5
    '{1'b1, 12'h280, 32'hFFFF_FFFF,1'b0, 32'h0,        1'b0, 4'd5},  // R5
    '{1'b1, 12'h284, 32'hFFFF_FFFF,1'b0, 32'h0,        1'b0, 4'd5},  // R5
    '{1'b0, 12'h280, 32'h0,        1'b1, 32'hF0,       1'b0, 4'd5},  // R5
    '{1'b0, 12'h200, 32'h0,        1'b1, 32'hF0,       1'b0, 4'd5},  // R5
    '{1'b0, 12'h300, 32'h0,        1'b1, 32'hF0,       1'b0, 4'd6},  // R6
    '{1'b0, 12'h304, 32'h0,        1'b1, 32'h8000_0001,1'b0, 4'd6},  // R6
    '{1'b1, 12'h300, 32'h0,        1'b0, 32'h0,        1'b0, 4'd6},  // R6
    '{1'b1, 12'h304, 32'h0,        1'b0, 32'h0,        1'b0, 4'd6},  // R6
    '{1'b0, 12'h300, 32'h0,        1'b1, 32'hF0,       1'b0, 4'd6},  // R6
    '{1'b1, 12'h3C0, 32'hAB12_3456,1'b0, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b1, 12'h3C4, 32'hFFFF_FFFF,1'b0, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b0, 12'h3C0, 32'h0,        1'b1, 32'h0012_3456,1'b0, 4'd7},  // R7
    '{1'b0, 12'h3C4, 32'h0,        1'b1, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b1, 12'h740, 32'h00FF_FFFF,1'b0, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b1, 12'h744, 32'h1,        1'b0, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b0, 12'h740, 32'h0,        1'b1, 32'h00FF_FFFF,1'b0, 4'd7},  // R7
    '{1'b1, 12'h640, 32'h1,        1'b0, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b1, 12'h644, 32'h1,        1'b0, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b0, 12'h640, 32'h0,        1'b1, 32'h1,        1'b0, 4'd3},  // R3
    '{1'b0, 12'h644, 32'h0,        1'b1, 32'h1,        1'b0, 4'd3},  // R3
    '{1'b1, 12'h040, 32'h5,        1'b0, 32'h0,        1'b0, 4'd9},  // R9
    '{1'b1, 12'h044, 32'h5,        1'b0, 32'h0,        1'b0, 4'd9},  // R9
    '{1'b0, 12'h040, 32'h0,        1'b1, 32'h0,        1'b0, 4'd9},  // R9
    '{1'b0, 12'h780, 32'h0,        1'b1, 32'h0,        1'b0, 4'd9},  // R9
    '{1'b0, 12'h800, 32'h0,        1'b1, 32'hFFFF_FFFF,1'b1, 4'd10}, // R10
    '{1'b1, 12'h200, 32'h55,       1'b0, 32'h0,        1'b0, 4'd10}, // R10
    '{1'b0, 12'h800, 32'h0,        1'b1, 32'hFFFF_FFFF,1'b1, 4'd10}, // R10
    '{1'b1, 12'h7C4, 32'h1,        1'b0, 32'h0,        1'b1, 4'd10}, // R10
    '{1'b1, 12'h201, 32'h9,        1'b0, 32'h0,        1'b1, 4'd10}, // R10
    '{1'b0, 12'h202, 32'h0,        1'b1, 32'hFFFF_FFFF,1'b1, 4'd10}, // R10
    '{1'b1, 12'h204, 32'h0,        1'b0, 32'h0,        1'b0, 4'd10}, // R10
    '{1'b0, 12'h200, 32'h0,        1'b1, 32'h55,       1'b0, 4'd10}, // R10
    '{1'b0, 12'h204, 32'h0,        1'b1, 32'h0,        1'b0, 4'd10}  // R10
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic rd, input logic [11:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    #5;
    rdS = busRdData; errS = accessErr; irqS = cpuIrq;
    @(posedge clk);
    #1;
    busWrEn = 1'b0; busRdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R1 idle irq", 64'(cpuIrq), 64'h0);
    check("R1 idle rdData", 64'(busRdData), 64'h0);

    rawReq = 64'h8000_0001_0000_00F0;
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].wr, !VECS[i].wr, VECS[i].addr, VECS[i].data);
      check($sformatf("R%0d vec%0d err", VECS[i].req, i), 64'(errS), 64'(VECS[i].expErr));
      if (VECS[i].chkRd)
        check($sformatf("R%0d vec%0d rd", VECS[i].req, i), 64'(rdS), 64'(VECS[i].expRd));
    end

    // R8: mask0=0x55, mask3=0x1_0000_0001
    @(negedge clk);
    check("R8 irq table end", 64'(cpuIrq), 64'b1001);
    rawReq = 64'h0; #1;
    check("R8 irq raw zero", 64'(cpuIrq), 64'b0000);
    rawReq = 64'h1; #1;
    check("R8 irq raw bit0", 64'(cpuIrq), 64'b1001);

    // R8: mask0 commit to zero in the same cycle rawReq changes
    access(1'b1, 1'b0, 12'h200, 32'h0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 12'h204; busWrData = 32'h0; rawReq = 64'h4;
    #5;
    check("R8 same-cycle before edge", 64'(cpuIrq), 64'b0001);
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
    check("R8 same-cycle after edge", 64'(cpuIrq), 64'b0000);

    access(1'b1, 1'b0, 12'h600, 32'h4);
    access(1'b1, 1'b0, 12'h604, 32'h0);
    check("R8 before commit", 64'(irqS), 64'b0000);
    check("R8 after commit", 64'(cpuIrq), 64'b0100);

    // R11: write and read enabled together
    access(1'b1, 1'b1, 12'h380, 32'h77);
    check("R11 dual rdData", 64'(rdS), 64'h0);
    check("R11 dual err", 64'(errS), 64'h0);
    access(1'b1, 1'b0, 12'h384, 32'h0);
    access(1'b0, 1'b1, 12'h380, 32'h0);
    check("R11 latch from write", 64'(rdS), 64'h77);

    // R1: reset again with every raw request asserted
    rawReq = '1;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1 irq after reset", 64'(cpuIrq), 64'h0);
    access(1'b0, 1'b1, 12'h204, 32'h0);
    check("R1 latch after reset", 64'(rdS), 64'h0);
    access(1'b0, 1'b1, 12'h640, 32'h0);
    check("R1 mask3 after reset", 64'(rdS), 64'h0);
    access(1'b0, 1'b1, 12'h3C0, 32'h0);
    check("R1 iic1 after reset", 64'(rdS), 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule